// File: doc/BRIEF.md
# Variable-Width Byte FIFO for Indirect Flash Transfers

This block is the data buffer between a 32-bit register port and the byte stream of a serial flash controller's data phase. It holds up to 16 bytes. A register access moves 1, 2 or 4 bytes at once, depending on its size. The serial engine moves exactly one byte per cycle.

A direction input sets which side fills the buffer and which side drains it:

- **Write direction:** register writes fill the buffer and the serial engine drains it.
- **Read direction:** the serial engine fills the buffer and register reads drain it.

When a register access cannot complete, it is held off by keeping its acknowledge low. A write waits until there is room for all of its bytes. A read waits until all of its bytes have arrived or the transfer-done input says no more will come.

The block reports its fill level. It also reports a threshold flag whose meaning depends on the direction. In read direction the flag also signals bytes left over at the end of a transfer.

Top module: `xfer_byte_fifo`

## Requirements
- R1: After reset the level is 0. In write direction with threshold 3, the flag is 1 right after reset.
- R2: The buffer holds 16 bytes and `level_o` spans 0 to 16. A serial push in read direction is accepted only while the level is below 16; otherwise it is dropped.
- R3: `reg_size_i` gives the byte count of an access: 00 is 1 byte, 01 is 2 bytes, 10 and 11 are 4 bytes. An acknowledged write stores bytes [7:0], then [15:8], and so on up to the access size. The lowest lane is stored first. Upper lanes beyond the access size are discarded.
- R4: In write direction a register write is acknowledged only when free space (16 minus level) is at least its byte count. While held off it stores nothing.
- R5: An acknowledged read removes its bytes, oldest first. The oldest byte appears on `reg_rdata_o[7:0]`, the next on [15:8], and so on. Bits above the access size are zero.
- R6: In read direction, while `xfer_done_i` is 0, a register read is held off as long as the level is below its byte count.
- R7: While `xfer_done_i` is 1, a register read is acknowledged at once. It takes whatever bytes remain, the level drops by that number, and missing lanes read as zero.
- R8: In read direction the flag is 1 when either of these holds: the level is at least threshold+1, or `xfer_done_i` is 1 and the level is nonzero. Otherwise the flag is 0.
- R9: In write direction the flag is 1 when free space is at least threshold+1, and 0 otherwise.
- R10: Three kinds of access are ignored and leave the level unchanged:
  - A register access in the wrong direction (a write in read direction, or a read in write direction). It is acknowledged at once and reads zero.
  - A serial pop in read direction.
  - A serial push in write direction.
- R11: In write direction a serial pop outputs the oldest byte on `ser_pop_data_o` and removes it. A pop on an empty buffer reads 0 and leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rd_i | input | 1 | 1: serial fills, register drains; 0: register fills, serial drains |
| thresh_i | input | 4 | Threshold value; condition uses threshold+1 |
| xfer_done_i | input | 1 | Serial transfer has finished; no more bytes will arrive |
| reg_req_i | input | 1 | Register access request, held until acknowledged |
| reg_we_i | input | 1 | 1 for a register write, 0 for a read |
| reg_size_i | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| reg_wdata_i | input | 32 | Write data, low lanes used first |
| reg_ack_o | output | 1 | Access completes at this clock edge |
| reg_rdata_o | output | 32 | Read data, valid with acknowledge |
| ser_push_i | input | 1 | Serial engine delivers one byte |
| ser_push_data_i | input | 8 | Byte delivered by serial engine |
| ser_pop_i | input | 1 | Serial engine takes one byte |
| ser_pop_data_o | output | 8 | Oldest byte, taken on pop |
| level_o | output | 5 | Bytes held, 0 to 16 |
| thresh_flag_o | output | 1 | Direction-dependent threshold flag |

## Verification
The bench fills the buffer to exactly 16 bytes with a mix of byte, halfword and word writes whose upper lanes carry junk.

- If the design miscounted an access size, the levels and the drained byte stream would go wrong.
- If it stored unused lanes, extra bytes would appear in the drained stream.

At full and near-full it tries writes that need more room than is free. A design that accepted them would overwrite unread bytes. A design that stalled too eagerly would hold off a halfword write that fits.

In read direction the bench checks three cases:

- A word read with three bytes present must stall until the fourth arrives.
- After the done indication, a short read must return zeros in its empty lanes and leave the buffer empty. A design that kept stalling would never acknowledge.
- The threshold flag must rise on leftover data only once the transfer is done.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned CW    = $clog2(LANES + 1);

  // 00 -> 1, 01 -> 2, 1x -> 4
  function automatic logic [CW-1:0] access_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return CW'(1);
      2'b01:   return CW'(2);
      default: return CW'(4);
    endcase
  endfunction
endpackage

// File: rtl/fifo_byte_store.sv
module fifo_byte_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CW-1:0]      push_cnt_i,
  input  logic [8*LANES-1:0] push_data_i,
  input  logic [CW-1:0]      pop_cnt_i,
  output logic [8*LANES-1:0] peek_o,
  output logic [LW-1:0]      level_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr + AW'(push_cnt_i);
      rptr  <= rptr + AW'(pop_cnt_i);
      level <= level + LW'(push_cnt_i) - LW'(pop_cnt_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LANES; i++) begin
      if (CW'(i) < push_cnt_i) mem[wptr + AW'(i)] <= push_data_i[8*i +: 8];
    end
  end

  // lanes past the fill level read as zero
  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_o[8*g +: 8] = (LW'(g) < level) ? mem[rptr + AW'(g)] : 8'h00;
  end

  assign level_o = level;

  // R2
  level_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= LW'(DEPTH));
endmodule

// File: rtl/fifo_access_gate.sv
module fifo_access_gate
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             mode_rd_i,
  input  logic             xfer_done_i,
  input  logic [LW-1:0]    level_i,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_size_i,
  input  logic             ser_push_i,
  input  logic             ser_pop_i,
  output logic             reg_ack_o,
  output logic [LANES-1:0] rd_lane_en_o,
  output logic [CW-1:0]    push_cnt_o,
  output logic [CW-1:0]    pop_cnt_o
);
  logic [CW-1:0] nbytes;
  logic [LW-1:0] free;
  logic          wr_match, rd_match, mismatch;
  logic          wr_ok, rd_ok, ser_push_ok, ser_pop_ok;
  logic [CW-1:0] rd_take;

  assign nbytes   = access_bytes(reg_size_i);
  assign free     = LW'(DEPTH) - level_i;
  assign wr_match = reg_req_i &&  reg_we_i && !mode_rd_i;
  assign rd_match = reg_req_i && !reg_we_i &&  mode_rd_i;
  assign mismatch = reg_req_i && !wr_match && !rd_match;

  assign wr_ok = free >= LW'(nbytes);
  assign rd_ok = (level_i >= LW'(nbytes)) || xfer_done_i;

  assign ser_push_ok = mode_rd_i  && ser_push_i && (level_i != LW'(DEPTH));
  assign ser_pop_ok  = !mode_rd_i && ser_pop_i  && (level_i != '0);

  assign rd_take = (LW'(nbytes) <= level_i) ? nbytes : CW'(level_i);

  assign reg_ack_o = mismatch || (wr_match && wr_ok) || (rd_match && rd_ok);

  always_comb begin
    if (mode_rd_i) begin
      push_cnt_o = ser_push_ok ? CW'(1) : '0;
      pop_cnt_o  = (rd_match && rd_ok) ? rd_take : '0;
    end else begin
      push_cnt_o = (wr_match && wr_ok) ? nbytes : '0;
      pop_cnt_o  = ser_pop_ok ? CW'(1) : '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_lane_en_o[g] = rd_match && rd_ok && (CW'(g) < nbytes);
  end
endmodule

// File: rtl/fifo_level_flag.sv
module fifo_level_flag #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          mode_rd_i,
  input  logic          xfer_done_i,
  input  logic [LW-1:0] level_i,
  input  logic [TW-1:0] thresh_i,
  output logic          flag_o
);
  logic [LW-1:0] thr1, free;

  assign thr1 = LW'(thresh_i) + LW'(1);
  assign free = LW'(DEPTH) - level_i;

  always_comb begin
    if (mode_rd_i) flag_o = (level_i >= thr1) || (xfer_done_i && level_i != '0);
    else           flag_o = free >= thr1;
  end
endmodule

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned DW = 8 * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_rd_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          xfer_done_i,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_size_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic          reg_ack_o,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          ser_push_i,
  input  logic [7:0]    ser_push_data_i,
  input  logic          ser_pop_i,
  output logic [7:0]    ser_pop_data_o,
  output logic [LW-1:0] level_o,
  output logic          thresh_flag_o
);
  logic [CW-1:0]    push_cnt, pop_cnt;
  logic [DW-1:0]    push_data, peek;
  logic [LANES-1:0] rd_lane_en;
  logic [LW-1:0]    level;
  logic [CW-1:0]    req_bytes;

  assign push_data = mode_rd_i ? DW'(ser_push_data_i) : reg_wdata_i;
  assign req_bytes = access_bytes(reg_size_i);

  fifo_byte_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_cnt_i  (push_cnt),
    .push_data_i (push_data),
    .pop_cnt_i   (pop_cnt),
    .peek_o      (peek),
    .level_o     (level)
  );

  fifo_access_gate #(.DEPTH(DEPTH)) u_gate (
    .mode_rd_i    (mode_rd_i),
    .xfer_done_i  (xfer_done_i),
    .level_i      (level),
    .reg_req_i    (reg_req_i),
    .reg_we_i     (reg_we_i),
    .reg_size_i   (reg_size_i),
    .ser_push_i   (ser_push_i),
    .ser_pop_i    (ser_pop_i),
    .reg_ack_o    (reg_ack_o),
    .rd_lane_en_o (rd_lane_en),
    .push_cnt_o   (push_cnt),
    .pop_cnt_o    (pop_cnt)
  );

  fifo_level_flag #(.DEPTH(DEPTH), .TW(TW)) u_flag (
    .mode_rd_i   (mode_rd_i),
    .xfer_done_i (xfer_done_i),
    .level_i     (level),
    .thresh_i    (thresh_i),
    .flag_o      (thresh_flag_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_rdata
    assign reg_rdata_o[8*g +: 8] = rd_lane_en[g] ? peek[8*g +: 8] : 8'h00;
  end

  assign ser_pop_data_o = peek[7:0];
  assign level_o        = level;

  // R4
  wr_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && !mode_rd_i && !reg_ack_o) |=> (level_o <= $past(level_o)));

  // R7
  short_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && mode_rd_i && xfer_done_i && !ser_push_i &&
     level_o < LW'(req_bytes)) |=> (level_o == '0));

  // R10
  wrong_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && (reg_we_i == mode_rd_i)) |-> (reg_ack_o && reg_rdata_o == '0));

  // R8
  flag_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_rd_i && level_o == '0) |-> !thresh_flag_o);
endmodule

// File: tb/xfer_byte_fifo_test.sv
module xfer_byte_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_rd = 1'b0;
  logic [3:0]  thresh = 4'd3;
  logic        done = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  sz = 2'b00;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        spush = 1'b0, spop = 1'b0;
  logic [7:0]  spush_d = '0;
  logic [7:0]  spop_d;
  logic [4:0]  level;
  logic        flag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  xfer_byte_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_rd_i(mode_rd), .thresh_i(thresh),
    .xfer_done_i(done), .reg_req_i(req), .reg_we_i(we), .reg_size_i(sz),
    .reg_wdata_i(wdata), .reg_ack_o(ack), .reg_rdata_o(rdata),
    .ser_push_i(spush), .ser_push_data_i(spush_d), .ser_pop_i(spop),
    .ser_pop_data_o(spop_d), .level_o(level), .thresh_flag_o(flag)
  );

  // {size, wdata}: mixed sizes summing to exactly 16 bytes
  localparam logic [33:0] VEC [8] = '{
    {2'b00, 32'h1234_56A0}, {2'b01, 32'h9999_B2B1},
    {2'b10, 32'hC4C3_C2C1}, {2'b00, 32'hFFFF_FFD0},
    {2'b01, 32'h5555_E2E1}, {2'b10, 32'hF4F3_F2F1},
    {2'b00, 32'hAAAA_AA77}, {2'b00, 32'h0000_0088}
  };

  logic [7:0] exp_q [16];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  task automatic reg_acc(input logic w, input logic [1:0] s, input logic [31:0] d,
                         input int max_wait, output logic acked, output logic [31:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; sz = s; wdata = d;
    acked = 1'b0; rd = '0;
    for (int k = 0; k <= max_wait && !acked; k++) begin
      #1;
      if (ack) begin acked = 1'b1; rd = rdata; end
      @(negedge clk);
    end
    req = 1'b0;
    #1;
  endtask

  task automatic ser_push(input logic [7:0] d);
    @(negedge clk);
    spush = 1'b1; spush_d = d;
    @(negedge clk);
    spush = 1'b0;
    #1;
  endtask

  task automatic ser_pop(output logic [7:0] d);
    @(negedge clk);
    spop = 1'b1;
    #1 d = spop_d;
    @(negedge clk);
    spop = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic        a;
    logic [31:0] r;
    logic [7:0]  b;
    int          lvl;
    int          qi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 level", 32'(level), 32'd0);
    chk("R1 flag", 32'(flag), 32'd1);

    // table walk: write direction, threshold 3
    lvl = 0; qi = 0;
    for (int i = 0; i < 8; i++) begin
      reg_acc(1'b1, VEC[i][33:32], VEC[i][31:0], 5, a, r);
      chk("R3 ack", 32'(a), 32'd1);
      for (int j = 0; j < nb(VEC[i][33:32]); j++) begin
        exp_q[qi] = VEC[i][8*j +: 8];
        qi++;
      end
      lvl += nb(VEC[i][33:32]);
      chk("R3 level", 32'(level), 32'(lvl));
      chk("R9 flag", 32'(flag), 32'((16 - lvl) >= 4));
    end

    // full: byte write must stall
    reg_acc(1'b1, 2'b00, 32'h0000_00EE, 5, a, r);
    chk("R4 stall full", 32'(a), 32'd0);
    chk("R4 level kept", 32'(level), 32'd16);
    // serial push in write direction ignored
    ser_push(8'h5A);
    chk("R10 push ignored", 32'(level), 32'd16);
    // register read in write direction
    reg_acc(1'b0, 2'b10, 32'h0, 2, a, r);
    chk("R10 wrong dir ack", 32'(a), 32'd1);
    chk("R10 wrong dir data", r, 32'd0);
    chk("R10 wrong dir level", 32'(level), 32'd16);

    ser_pop(b); chk("R11 pop0", 32'(b), 32'(exp_q[0]));
    ser_pop(b); chk("R11 pop1", 32'(b), 32'(exp_q[1]));
    chk("R11 level", 32'(level), 32'd14);
    reg_acc(1'b1, 2'b10, 32'hDEAD_0000, 5, a, r);
    chk("R4 word stall", 32'(a), 32'd0);
    chk("R4 word stall level", 32'(level), 32'd14);
    reg_acc(1'b1, 2'b01, 32'h7777_BEEF, 5, a, r);
    chk("R4 half fits", 32'(a), 32'd1);
    chk("R4 level 16", 32'(level), 32'd16);
    for (int i = 2; i < 16; i++) begin
      ser_pop(b); chk("R11 drain", 32'(b), 32'(exp_q[i]));
    end
    ser_pop(b); chk("R11 drain EF", 32'(b), 32'h EF);
    ser_pop(b); chk("R11 drain BE", 32'(b), 32'h BE);
    ser_pop(b);
    chk("R11 empty pop data", 32'(b), 32'd0);
    chk("R11 empty pop level", 32'(level), 32'd0);

    // read direction, threshold 1
    @(negedge clk);
    mode_rd = 1'b1; thresh = 4'd1; done = 1'b0;
    #1;
    chk("R8 flag empty", 32'(flag), 32'd0);
    for (int i = 0; i < 16; i++) ser_push(8'(8'h10 + i));
    chk("R2 full level", 32'(level), 32'd16);
    ser_push(8'hFF);
    chk("R2 push full dropped", 32'(level), 32'd16);
    for (int i = 0; i < 4; i++) begin
      reg_acc(1'b0, 2'b10, 32'h0, 5, a, r);
      chk("R5 word read", r, {8'(8'h13 + 4*i), 8'(8'h12 + 4*i), 8'(8'h11 + 4*i), 8'(8'h10 + 4*i)});
    end
    chk("R5 level 0", 32'(level), 32'd0);

    ser_push(8'h11); ser_push(8'h22); ser_push(8'h33);
    chk("R8 flag level3", 32'(flag), 32'd1);
    reg_acc(1'b0, 2'b10, 32'h0, 5, a, r);
    chk("R6 stall", 32'(a), 32'd0);
    chk("R6 level kept", 32'(level), 32'd3);
    ser_push(8'h44);
    reg_acc(1'b0, 2'b10, 32'h0, 5, a, r);
    chk("R6 released", 32'(a), 32'd1);
    chk("R5 data", r, 32'h4433_2211);

    ser_push(8'h77); ser_push(8'h88); ser_push(8'h99);
    reg_acc(1'b0, 2'b01, 32'h0, 5, a, r);
    chk("R5 half data", r, 32'h0000_8877);
    chk("R5 half level", 32'(level), 32'd1);
    chk("R8 flag one byte not done", 32'(flag), 32'd0);
    ser_pop(b);
    chk("R10 ser pop ignored", 32'(level), 32'd1);
    reg_acc(1'b1, 2'b00, 32'h0000_00AB, 2, a, r);
    chk("R10 write in read dir ack", 32'(a), 32'd1);
    chk("R10 write in read dir level", 32'(level), 32'd1);

    @(negedge clk); done = 1'b1; #1;
    chk("R8 leftover flag", 32'(flag), 32'd1);
    reg_acc(1'b0, 2'b10, 32'h0, 5, a, r);
    chk("R7 short ack", 32'(a), 32'd1);
    chk("R7 short data", r, 32'h0000_0099);
    chk("R7 level 0", 32'(level), 32'd0);
    chk("R8 flag cleared", 32'(flag), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule